// File: doc/BRIEF.md
# Chip Baseline Estimator and Subtractor

This block strips a shared baseline from a stream of per-channel samples coming out of a front-end stream parser. A single baseline value serves every channel of one front-end chip. The baseline is either entered directly on a manual input or estimated by the block itself. A one-cycle start strobe launches the estimate, which averages the next 128 qualified samples.

Each qualified sample passes through a two-stage register pipeline. When correction is enabled, the baseline is subtracted and the result is clamped at zero. When correction is disabled, the sample comes out unchanged. The valid qualifier travels alongside the data. While an estimate is being taken, the previous estimate stays in use, and the estimator reports that it is busy.

Top module: `pedestal_sub`

## Requirements
- R1: After reset, `out_valid`, `out_data`, `meas_busy` and the automatic baseline (seen on `ped_value` when `use_manual` is 0) are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R3: With `corr_en` high when a valid sample enters, the output sample is `in_data - ped_value` sampled in that same cycle, clamped to 0 when the baseline is greater than or equal to the sample.
- R4: With `corr_en` low when a valid sample enters, the output sample two cycles later equals the input sample.
- R5: With `use_manual` = 1, `ped_value` follows `man_ped` and is the value subtracted. With `use_manual` = 0, the automatic estimate is used.
- R6: A `meas_start` pulse while idle raises `meas_busy` on the next cycle. `meas_busy` falls in the cycle after the 128th valid sample that follows the start.
- R7: The automatic estimate is the sum of those 128 valid samples shifted right by 7 (floor of the mean). Cycles with `in_valid` low add nothing, and a sample arriving in the start cycle itself is not counted.
- R8: While `meas_busy` is high, the automatic baseline keeps its previous value.
- R9: A `meas_start` pulse while `meas_busy` is high is ignored, and the running estimate continues uninterrupted.
- R10: `out_data` holds its last value in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Parsed channel sample |
| in_valid | input | 1 | Qualifier for `in_data` |
| meas_start | input | 1 | Start strobe for automatic baseline estimation |
| man_ped | input | DW | Manually supplied baseline |
| use_manual | input | 1 | 1 selects `man_ped`, 0 selects the automatic estimate |
| corr_en | input | 1 | 1 subtracts the baseline, 0 passes data through |
| out_data | output | DW | Corrected sample |
| out_valid | output | 1 | Qualifier for `out_data` |
| ped_value | output | DW | Baseline currently selected |
| meas_busy | output | 1 | High while an estimate is in progress |

## Verification
Some properties are checked by assertions on every cycle:
- The valid qualifier moves step by step through the pipeline.
- A result never exceeds the sample it came from.
- The output holds while it is not qualified.
- The estimate register does not move while busy.
- The accumulator is clear whenever the estimator is idle.
- Busy can only drop after a qualified sample.

Other behaviour can only be shown by the bench scenarios:
- The exact arithmetic of subtraction and clamping.
- Bypass with correction disabled.
- The floor-of-mean value after a run with gaps in it.
- Ignoring a restart strobe mid-run.
- The point at which a new estimate takes over.

// File: rtl/pedestal_sub.sv
module pedestal_sub #(
  parameter int DW       = 12,
  parameter int AVG_LOG2 = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          meas_start,
  input  logic [DW-1:0] man_ped,
  input  logic          use_manual,
  input  logic          corr_en,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic [DW-1:0] ped_value,
  output logic          meas_busy
);
  localparam int ACC_W = DW + AVG_LOG2;

  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    acc_next;
  logic [AVG_LOG2-1:0] cnt;
  logic [DW-1:0]       auto_ped;
  logic                s1_valid;
  logic [DW-1:0]       s1_data;
  logic [DW-1:0]       s1_ped;

  assign acc_next  = acc + ACC_W'(in_data);
  assign ped_value = use_manual ? man_ped : auto_ped;

  // baseline estimator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      auto_ped  <= '0;
      meas_busy <= 1'b0;
    end else if (meas_busy) begin
      if (in_valid) begin
        cnt <= cnt + 1'b1;
        acc <= acc_next;
        if (cnt == '1) begin
          auto_ped  <= acc_next[ACC_W-1:AVG_LOG2];
          meas_busy <= 1'b0;
          acc       <= '0;
        end
      end
    end else if (meas_start) begin
      meas_busy <= 1'b1;
      cnt       <= '0;
      acc       <= '0;
    end
  end

  // two-stage correction pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_data   <= '0;
      s1_ped    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) begin
        s1_data <= in_data;
        s1_ped  <= corr_en ? ped_value : '0;
      end
      if (s1_valid)
        out_data <= (s1_data > s1_ped) ? s1_data - s1_ped : '0;
    end
  end

  p_valid_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= $past(s1_data));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  p_keep_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_busy && $past(meas_busy)) |-> $stable(auto_ped));
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_busy |-> (acc == '0 && cnt == '0));
  p_end_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(meas_busy) |-> $past(in_valid));
endmodule

// File: tb/tb_pedestal_sub.sv
module tb_pedestal_sub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        meas_start = 1'b0;
  logic [11:0] man_ped = '0;
  logic        use_manual = 1'b0;
  logic        corr_en = 1'b0;
  logic [11:0] out_data;
  logic        out_valid;
  logic [11:0] ped_value;
  logic        meas_busy;

  int checks = 0;
  int errors = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  bit          m_busy = 0;
  int          m_cnt = 0;
  int          m_sum = 0;
  logic [11:0] m_auto = '0;
  logic [11:0] last_out = '0;

  pedestal_sub dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .meas_start(meas_start), .man_ped(man_ped), .use_manual(use_manual),
    .corr_en(corr_en), .out_data(out_data), .out_valid(out_valid),
    .ped_value(ped_value), .meas_busy(meas_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] d, input logic v, input logic st, input string tag);
    logic [11:0] pnow;
    logic [11:0] e;
    bit old;
    @(negedge clk);
    in_data = d; in_valid = v; meas_start = st;
    pnow = corr_en ? (use_manual ? man_ped : m_auto) : 12'd0;
    e = (d > pnow) ? d - pnow : 12'd0;
    if (v) begin exp_q.push_back(e); tag_q.push_back(tag); end
    old = m_busy;
    if (m_busy && v) begin
      m_sum += int'(d); m_cnt++;
      if (m_cnt == 128) begin m_auto = 12'(m_sum / 128); m_busy = 0; end
    end
    if (st && !old) begin m_busy = 1; m_cnt = 0; m_sum = 0; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(12'hABC, 1'b0, 1'b0, "idle");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output", int'(out_data), -1);
      else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(out_data == e, t, int'(out_data), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(out_data == 0, "R1 out_data", out_data, 0);
    chk(meas_busy == 0, "R1 busy", meas_busy, 0);
    chk(ped_value == 0, "R1 auto baseline", ped_value, 0);
    rst_n = 1'b1;

    // manual baseline, R5 and R3
    use_manual = 1'b1; man_ped = 12'd100; corr_en = 1'b1;
    idle(2);
    chk(ped_value == 100, "R5 manual selected", ped_value, 100);
    send(12'd500, 1, 0, "R3 subtract");
    send(12'd50,  1, 0, "R3 clamp below");
    send(12'd100, 1, 0, "R3 clamp equal");
    send(12'd101, 1, 0, "R3 one above");
    idle(4);

    // latency R2
    send(12'd777, 1, 0, "R2 latency data");
    send(12'hABC, 0, 0, "idle");
    chk(out_valid == 0, "R2 not yet at 1 cycle", out_valid, 0);
    send(12'hABC, 0, 0, "idle");
    chk(out_valid == 1, "R2 valid at 2 cycles", out_valid, 1);
    last_out = 12'd677;
    send(12'hABC, 0, 0, "idle");
    chk(out_valid == 0, "R2 single pulse", out_valid, 0);

    // hold R10
    for (int i = 0; i < 4; i++) begin
      send(12'(i * 97), 0, 0, "idle");
      chk(out_data == last_out, "R10 hold", out_data, last_out);
    end

    // bypass R4
    corr_en = 1'b0;
    send(12'd37, 1, 0, "R4 bypass small");
    send(12'd4095, 1, 0, "R4 bypass max");
    idle(3);
    corr_en = 1'b1;

    // automatic estimate with gaps, R6 R7 R8 R9
    use_manual = 1'b0;
    idle(1);
    chk(ped_value == 0, "R5 auto selected", ped_value, 0);
    send(12'd999, 1, 1, "R7 start-cycle sample");
    send(12'hFFF, 0, 0, "idle");
    chk(meas_busy == 1, "R6 busy after start", meas_busy, 1);
    for (int i = 0; i < 128; i++) begin
      if (i % 5 == 2) send(12'hFFF, 0, 0, "idle");
      send(12'(200 + i % 16), 1, (i == 60), "R7 sample during run");
      if (i == 70) chk(ped_value == 0, "R8 old baseline kept", ped_value, 0);
      if (i < 127) chk(meas_busy == 1 || i == 0, "R9 busy continues", meas_busy, 1);
    end
    send(12'hABC, 0, 0, "idle");
    chk(meas_busy == 0, "R6 busy drops", meas_busy, 0);
    chk(ped_value == m_auto, "R7 mean value", ped_value, m_auto);
    chk(m_auto == 207, "R7 bench mean", m_auto, 207);
    send(12'd300, 1, 0, "R7 auto subtract");
    send(12'd10,  1, 0, "R3 auto clamp");
    idle(3);

    // full-scale estimate
    send(12'hABC, 0, 1, "idle");
    for (int i = 0; i < 128; i++) send(12'd4095, 1, 0, "R7 full scale sample");
    send(12'hABC, 0, 0, "idle");
    chk(ped_value == 4095, "R7 full-scale mean", ped_value, 4095);
    send(12'd4095, 1, 0, "R3 full-scale clamp");
    idle(4);

    chk(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule